// File: doc/BRIEF.md
# Serial Peripheral Master with Threshold-Interrupt Queues

This block is a serial peripheral bus master for one slave. Software writes 8-bit words into a four-entry transmit queue and reads received words out of a four-entry receive queue. Both queues sit behind a small register port with four addresses. The serial engine takes words from the transmit queue one at a time. It holds the select line low for the whole frame and returns each received word to the receive queue. Polarity, phase, shift direction and the serial clock rate are all configurable.

There are four interrupt conditions: transmit space, receive fill, idle and receive overrun. The transmit condition rises when enough queue slots are free, and the receive condition rises when enough words are waiting. A two-bit threshold code sets the level for each of these two. Every condition has its own enable, and the enable gates only the interrupt line. The raw condition stays readable in the status register whatever the enable. Between frames the engine inserts a programmable gap, counted either in clock cycles or in units of 32 cycles.

Register map (addresses on `wr_addr` and `rd_addr`):

- 0 is the control register, read and write:
  - [1:0] transmit threshold code
  - [3:2] receive threshold code
  - [4] transmit enable
  - [5] receive enable
  - [6] idle enable
  - [7] overrun enable
  - [8] shift order
  - [9] clock polarity
  - [10] clock phase
  - [11] gap prescale
  - [19:12] divider value D
  - [27:20] gap length G
- 1 is the transmit data port. A write pushes `wr_data[7:0]`.
- 2 is the receive data port. A read pops the oldest word. It returns 0 when the queue is empty.
- 3 is the status register:
  - [0] transmit condition
  - [1] receive condition
  - [2] idle
  - [3] overrun flag
  - [6:4] transmit queue count
  - [10:8] receive queue count

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control register reads 0, status reads 0x5 (transmit condition and idle set, both queues empty, overrun clear), `cs_n` is 1, `sclk` is 0 and `irq` is 0.
- R2: The transmit queue holds 4 words. A write to address 1 while it holds 4 words is dropped: the count stays 4 and that word is never sent. While a frame shifts, the count equals the words written minus the frames started.
- R3: Status bit 0 is 1 exactly when the free transmit slots (4 minus the count) are at least code+1. Status bit 1 is 1 exactly when the stored receive words are at least code+1. Codes 0 to 3 give levels 1 to 4.
- R4: `irq` is the OR of the four status conditions (bits 0 to 3), each ANDed with its enable. It is registered, so it follows a change one cycle later. A disabled condition still shows in status.
- R5: A word that finishes while the receive queue holds 4 words is discarded, and the overrun flag (status bit 3) is set. The flag stays set until a write to address 3 with bit 3 at 1. A write with bit 3 at 0 leaves it unchanged.
- R6: The idle bit is 1 only when the transmit queue is empty, no frame is active and the inter-frame gap has run out.
- R7: Between back-to-back frames `cs_n` stays high for G+2 clock cycles with prescale 0, and for 32·G+2 cycles with prescale 1.
- R8: With the shift order at 0 the word goes out MSB first. With it at 1 the word goes out LSB first. The received word is assembled in the same order.
- R9: While `cs_n` is high, `sclk` rests at the polarity bit. A frame has 16 `sclk` edges, each half period lasting D+1 clock cycles. With phase 0 data is sampled on the first edge of each pair. With phase 1 it is sampled on the second.
- R10: Each frame shifts in `miso` on the sampling edges and pushes the result to the receive queue. Reads from address 2 return the words in arrival order, and the data appears one cycle after `rd_en`.
- R11: The receive queue holds 4 words, and its status count never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A bad queue count shows up in the status count fields and the threshold bits on the very next status read. It then shows as a missing, repeated or extra word once the queued frames have drained. A wrong shift pointer or sampling edge changes the bit pattern seen on `mosi` during the same frame, and changes the received word as soon as that frame ends. A gap counter that is off by one changes the measured high time of `cs_n` by whole cycles or by whole 32-cycle units. A stuck overrun or idle flag shows on `irq` one cycle after its enable is set.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int GAP_W  = 8;
  localparam int LVL_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int ST_OVR_BIT = 3;

  typedef struct packed {
    logic [3:0]       spare;
    logic [GAP_W-1:0] gap;
    logic [DIV_W-1:0] div;
    logic             gap_pre;
    logic             cpha;
    logic             cpol;
    logic             lsb_first;
    logic             ovr_ie;
    logic             idle_ie;
    logic             rx_ie;
    logic             tx_ie;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
  } ctrl_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int FRAME_W   = 8,
  parameter int PRE_RATIO = 32,
  localparam int EDGE_W = $clog2(2 * FRAME_W + 1),
  localparam int PRE_W  = $clog2(PRE_RATIO)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               lsb_first,
  input  logic               gap_pre,
  input  logic [DIV_W-1:0]   div,
  input  logic [GAP_W-1:0]   gap,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_word,
  output logic               eng_idle,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);

  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_W);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_RATIO - 1);

  eng_state_t         st;
  logic [DIV_W-1:0]   tmr;
  logic [EDGE_W-1:0]  edge_q;
  logic [FRAME_W-1:0] tx_sh, rx_sh, tx_next, rx_next;
  logic [GAP_W-1:0]   gap_cnt;
  logic [PRE_W-1:0]   pre_cnt;
  logic               tick, sample_now, launch_now;

  assign tick       = (st == ENG_SHIFT) && (tmr == div);
  // phase 0 samples even edges, phase 1 samples odd edges
  assign sample_now = (edge_q[0] == cpha);
  assign launch_now = (edge_q[0] != cpha) && (edge_q != '0);

  assign tx_next = lsb_first ? {1'b0, tx_sh[FRAME_W-1:1]} : {tx_sh[FRAME_W-2:0], 1'b0};
  assign rx_next = lsb_first ? {miso, rx_sh[FRAME_W-1:1]} : {rx_sh[FRAME_W-2:0], miso};

  assign tx_pop   = (st == ENG_IDLE) && !tx_empty;
  assign rx_push  = tick && (edge_q == LAST_EDGE);
  assign rx_word  = rx_sh;
  assign eng_idle = (st == ENG_IDLE);
  assign mosi     = lsb_first ? tx_sh[0] : tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ENG_IDLE;
      tmr     <= '0;
      edge_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      gap_cnt <= '0;
      pre_cnt <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (st)
        ENG_IDLE: begin
          sclk <= cpol;
          cs_n <= 1'b1;
          if (!tx_empty) begin
            tx_sh  <= tx_word;
            cs_n   <= 1'b0;
            edge_q <= '0;
            tmr    <= '0;
            st     <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (tmr == div) begin
            tmr <= '0;
            if (edge_q == LAST_EDGE) begin
              cs_n    <= 1'b1;
              gap_cnt <= gap;
              pre_cnt <= '0;
              st      <= ENG_GAP;
            end else begin
              sclk   <= ~sclk;
              edge_q <= edge_q + 1'b1;
              if (sample_now) rx_sh <= rx_next;
              if (launch_now) tx_sh <= tx_next;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ENG_GAP: begin
          sclk <= cpol;
          if (gap_cnt == '0) begin
            st <= ENG_IDLE;
          end else if (!gap_pre || pre_cnt == PRE_LAST) begin
            gap_cnt <= gap_cnt - 1'b1;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic             tx_ie,
  input  logic             rx_ie,
  input  logic             idle_ie,
  input  logic             ovr_ie,
  input  logic             idle,
  input  logic             ovr,
  output logic             tx_cond,
  output logic             rx_cond,
  output logic             irq
);

  logic [CNT_W-1:0] tx_free, tx_need, rx_need;

  assign tx_free = CNT_W'(DEPTH) - tx_count;
  assign tx_need = CNT_W'(tx_lvl) + CNT_W'(1);
  assign rx_need = CNT_W'(rx_lvl) + CNT_W'(1);
  assign tx_cond = (tx_free >= tx_need);
  assign rx_cond = (rx_count >= rx_need);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (tx_cond && tx_ie) || (rx_cond && rx_ie) ||
                    (idle && idle_ie) || (ovr && ovr_ie);
  end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int FRAME_W   = 8,
  parameter int PRE_RATIO = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int CNT_W   = $clog2(DEPTH) + 1;
  localparam int TXC_LSB = 4;
  localparam int RXC_LSB = TXC_LSB + CNT_W + 1;

  ctrl_t              ctrl;
  logic               ovr, idle, eng_idle;
  logic               tx_push, tx_pop, tx_full, tx_empty;
  logic               rx_push, rx_pop, rx_full, rx_empty;
  logic [CNT_W-1:0]   tx_count, rx_count;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
  logic               tx_cond, rx_cond, ovr_clr;
  logic [DATA_W-1:0]  status_w;

  assign tx_push = wr_en && (wr_addr == A_TXD);
  assign rx_pop  = rd_en && (rd_addr == A_RXD);
  assign ovr_clr = wr_en && (wr_addr == A_STAT) && wr_data[ST_OVR_BIT];
  assign idle    = eng_idle && tx_empty;

  spi_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .push(tx_push), .din(wr_data[FRAME_W-1:0]),
    .pop(tx_pop), .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  spi_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  spi_shift_engine #(.FRAME_W(FRAME_W), .PRE_RATIO(PRE_RATIO)) eng_i (
    .clk(clk), .rst(rst), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .lsb_first(ctrl.lsb_first), .gap_pre(ctrl.gap_pre), .div(ctrl.div), .gap(ctrl.gap),
    .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .eng_idle(eng_idle),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  spi_irq_ctrl #(.DEPTH(DEPTH)) irq_i (
    .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
    .tx_lvl(ctrl.tx_lvl), .rx_lvl(ctrl.rx_lvl), .tx_ie(ctrl.tx_ie), .rx_ie(ctrl.rx_ie),
    .idle_ie(ctrl.idle_ie), .ovr_ie(ctrl.ovr_ie), .idle(idle), .ovr(ovr),
    .tx_cond(tx_cond), .rx_cond(rx_cond), .irq(irq)
  );

  always_comb begin
    status_w = '0;
    status_w[0] = tx_cond;
    status_w[1] = rx_cond;
    status_w[2] = idle;
    status_w[ST_OVR_BIT] = ovr;
    status_w[TXC_LSB +: CNT_W] = tx_count;
    status_w[RXC_LSB +: CNT_W] = rx_count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ovr  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl <= ctrl_t'(wr_data);
      if (rx_push && rx_full) ovr <= 1'b1;
      else if (ovr_clr)       ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= DATA_W'(ctrl);
        A_RXD:   rd_data <= rx_empty ? '0 : DATA_W'(rx_head);
        A_STAT:  rd_data <= status_w;
        default: rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              ovr,
  input logic              idle,
  input logic              cs_n,
  input logic              sclk,
  input logic              cpol,
  input logic [3:0]        ens,
  input logic              irq
);

  logic clr;
  assign clr = wr_en && (wr_addr == A_STAT) && wr_data[ST_OVR_BIT];

  a_r2_tx_bounded: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CNT_W'(DEPTH));

  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_TXD && tx_count == CNT_W'(DEPTH) && !tx_pop)
      |=> (tx_count == CNT_W'(DEPTH)));

  a_r11_rx_bounded: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH));

  a_r5_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_count == CNT_W'(DEPTH)) |=> ovr);

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle |-> (tx_count == '0 && cs_n));

  a_r9_select_level: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk == cpol));

  a_r4_all_masked: assert property (@(posedge clk) disable iff (rst)
    (ens == 4'b0) |=> !irq);

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_count(tx_count), .rx_count(rx_count), .tx_pop(tx_pop), .rx_push(rx_push),
  .ovr(ovr), .idle(idle), .cs_n(cs_n), .sclk(sclk), .cpol(ctrl.cpol),
  .ens({ctrl.ovr_ie, ctrl.idle_ie, ctrl.rx_ie, ctrl.tx_ie}), .irq(irq)
);

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/100ps
module spi_fifo_master_tb_top;
  import spi_fifo_pkg::*;

  logic        clk, rst, wr_en, rd_en, irq, sclk, cs_n, mosi, miso;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  int n_checks = 0;
  int n_err    = 0;

  // monitor state
  bit          cur_cpol, cur_cpha;
  int          cur_div;
  logic [7:0]  mon_bits;
  int          mon_edges, mon_cnt, hp_bad, lvl_bad, last_gap;
  logic [7:0]  mon_word [16];
  int          mon_edge [16];
  realtime     last_t, t_rise;

  logic [7:0]  txw [8];

  assign miso = ~mosi;

  spi_fifo_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial monitor
  always @(negedge cs_n) begin
    if (sclk !== cur_cpol) lvl_bad++;
    mon_bits  = 8'h0;
    mon_edges = 0;
    last_gap  = $rtoi(($realtime - t_rise) / 5.0 + 0.5);
  end

  always @(posedge cs_n) begin
    t_rise = $realtime;
    if (mon_cnt < 16) begin
      mon_word[mon_cnt] = mon_bits;
      mon_edge[mon_cnt] = mon_edges;
    end
    mon_cnt++;
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      if (mon_edges > 0) begin
        if (($realtime - last_t) > (cur_div + 1) * 5.0 + 0.5 ||
            ($realtime - last_t) < (cur_div + 1) * 5.0 - 0.5) hp_bad++;
      end
      last_t = $realtime;
      mon_edges++;
      if ((sclk === 1'b1) == (cur_cpol == cur_cpha)) mon_bits = {mon_bits[6:0], mosi};
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [1:0] tl, input logic [1:0] rl,
      input logic [3:0] ie, input bit lsb, input bit pol, input bit pha,
      input bit pre, input logic [7:0] dv, input logic [7:0] gp);
    ctrl_t c;
    c = '0;
    c.tx_lvl = tl; c.rx_lvl = rl;
    c.tx_ie = ie[0]; c.rx_ie = ie[1]; c.idle_ie = ie[2]; c.ovr_ie = ie[3];
    c.lsb_first = lsb; c.cpol = pol; c.cpha = pha; c.gap_pre = pre;
    c.div = dv; c.gap = gp;
    return 32'(c);
  endfunction

  function automatic bit exp_irq(input logic [31:0] st, input logic [3:0] ie);
    return (st[0] & ie[0]) | (st[1] & ie[1]) | (st[2] & ie[2]) | (st[3] & ie[3]);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic burst(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_addr = A_TXD; wr_data = {24'h0, txw[i]};
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(A_STAT, s);
      if (s[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] c);
    ctrl_t cc;
    cc = ctrl_t'(c);
    cur_cpol = cc.cpol; cur_cpha = cc.cpha; cur_div = int'(cc.div);
    wr(A_CTRL, c);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frames(input int n, input bit lsb);
    logic [7:0] e;
    chk(mon_cnt == n, "R2 frame count", mon_cnt, n);
    for (int i = 0; i < n && i < 16; i++) begin
      e = lsb ? rev8(txw[i]) : txw[i];
      chk(mon_word[i] == e, "R8 serial bit order", {24'h0, mon_word[i]}, {24'h0, e});
      chk(mon_edge[i] == 16, "R9 edges per frame", mon_edge[i], 16);
    end
    chk(hp_bad == 0, "R9 half period", hp_bad, 0);
    chk(lvl_bad == 0, "R9 idle clock level", lvl_bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] s, d, c;
    logic [1:0]  tl, rl;
    logic [3:0]  ie;
    bit          lsb, pol, pha;
    int          n;

    void'($urandom(32'd4711));
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0; rst = 1'b1;
    cur_cpol = 0; cur_cpha = 0; cur_div = 0;
    mon_cnt = 0; hp_bad = 0; lvl_bad = 0; last_gap = 0; t_rise = 0.0; last_t = 0.0;
    mon_edges = 0; mon_bits = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n after reset", {31'h0, cs_n}, 1);
    chk(sclk === 1'b0, "R1 sclk after reset", {31'h0, sclk}, 0);
    chk(irq === 1'b0, "R1 irq after reset", {31'h0, irq}, 0);
    rd(A_CTRL, d);
    chk(d == 32'h0, "R1 control reset", d, 0);
    rd(A_STAT, d);
    chk(d == 32'h5, "R1 status reset", d, 32'h5);
    chk(irq === 1'b0, "R4 masked tx condition keeps irq low", {31'h0, irq}, 0);

    // random trials
    for (int t = 0; t < 20; t++) begin
      wait_idle();
      tl = 2'($urandom); rl = 2'($urandom); ie = 4'($urandom) & 4'b0111;
      lsb = 1'($urandom); pol = 1'($urandom); pha = 1'($urandom);
      c = mk_ctrl(tl, rl, ie, lsb, pol, pha, 1'b0, 8'(12 + $urandom % 9), 8'($urandom % 8));
      set_cfg(c);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) txw[i] = 8'($urandom);
      mon_cnt = 0; hp_bad = 0; lvl_bad = 0;
      burst(n);
      rd(A_STAT, s);
      chk(s[6:4] == 3'(n - 1), "R2 transmit count while shifting", {29'h0, s[6:4]}, n - 1);
      chk(s[0] == ((4 - (n - 1)) >= (tl + 1)), "R3 transmit threshold", {31'h0, s[0]},
          {31'h0, 1'((4 - (n - 1)) >= (tl + 1))});
      chk(s[2] == 1'b0, "R6 not idle while busy", {31'h0, s[2]}, 0);
      @(negedge clk);
      chk(irq == exp_irq(s, ie), "R4 irq while busy", {31'h0, irq}, {31'h0, exp_irq(s, ie)});
      wait_idle();
      rd(A_STAT, s);
      chk(s[10:8] == 3'(n), "R11 receive count", {29'h0, s[10:8]}, n);
      chk(s[1] == (n >= (rl + 1)), "R3 receive threshold", {31'h0, s[1]},
          {31'h0, 1'(n >= (rl + 1))});
      chk(s[2] == 1'b1, "R6 idle after drain", {31'h0, s[2]}, 1);
      @(negedge clk);
      chk(irq == exp_irq(s, ie), "R4 irq when idle", {31'h0, irq}, {31'h0, exp_irq(s, ie)});
      for (int i = 0; i < n; i++) begin
        rd(A_RXD, d);
        chk(d == {24'h0, ~txw[i]}, "R10 received word", d, {24'h0, ~txw[i]});
      end
      check_frames(n, lsb);
    end

    // fastest divider, directed
    wait_idle();
    set_cfg(mk_ctrl(2'd0, 2'd0, 4'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0));
    txw[0] = 8'hA5; txw[1] = 8'h3C;
    mon_cnt = 0; hp_bad = 0; lvl_bad = 0;
    burst(2);
    wait_idle();
    for (int i = 0; i < 2; i++) begin
      rd(A_RXD, d);
      chk(d == {24'h0, ~txw[i]}, "R10 received word at divider 0", d, {24'h0, ~txw[i]});
    end
    check_frames(2, 1'b0);

    // overrun and full-queue write
    set_cfg(mk_ctrl(2'd0, 2'd3, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 8'd0));
    for (int i = 0; i < 6; i++) txw[i] = 8'h11 * 8'(i + 1);
    mon_cnt = 0; hp_bad = 0; lvl_bad = 0;
    burst(6);
    rd(A_STAT, s);
    chk(s[6:4] == 3'd4, "R2 full queue keeps count 4", {29'h0, s[6:4]}, 4);
    chk(s[0] == 1'b0, "R3 no free slot", {31'h0, s[0]}, 0);
    wait_idle();
    rd(A_STAT, s);
    chk(s[3] == 1'b1, "R5 overrun flagged", {31'h0, s[3]}, 1);
    chk(s[10:8] == 3'd4, "R11 receive queue full at 4", {29'h0, s[10:8]}, 4);
    chk(s[1] == 1'b1, "R3 receive code 3 at 4 words", {31'h0, s[1]}, 1);
    @(negedge clk);
    chk(irq == 1'b1, "R4 overrun irq enabled", {31'h0, irq}, 1);
    for (int i = 0; i < 4; i++) begin
      rd(A_RXD, d);
      chk(d == {24'h0, ~txw[i]}, "R5 kept words, fifth dropped", d, {24'h0, ~txw[i]});
    end
    rd(A_RXD, d);
    chk(d == 32'h0, "R10 empty read returns 0", d, 0);
    check_frames(5, 1'b1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, s);
    chk(s[3] == 1'b1, "R5 overrun sticky", {31'h0, s[3]}, 1);
    wr(A_STAT, 32'h8);
    rd(A_STAT, s);
    chk(s[3] == 1'b0, "R5 overrun cleared", {31'h0, s[3]}, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R4 irq drops after clear", {31'h0, irq}, 0);

    // gap timing, unscaled
    set_cfg(mk_ctrl(2'd0, 2'd0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd5));
    txw[0] = 8'h01; txw[1] = 8'h02; txw[2] = 8'h03;
    mon_cnt = 0;
    burst(3);
    wait_idle();
    chk(last_gap == 7, "R7 gap without prescale", last_gap, 7);
    for (int i = 0; i < 3; i++) rd(A_RXD, d);

    // gap timing, prescaled
    set_cfg(mk_ctrl(2'd0, 2'd0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'd3));
    mon_cnt = 0;
    burst(3);
    wait_idle();
    chk(last_gap == 98, "R7 gap with prescale", last_gap, 98);
    for (int i = 0; i < 3; i++) rd(A_RXD, d);

    // idle held off during gap
    set_cfg(mk_ctrl(2'd0, 2'd0, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'd3));
    burst(1);
    @(posedge cs_n);
    repeat (40) @(negedge clk);
    rd(A_STAT, s);
    chk(s[2] == 1'b0, "R6 not idle during gap", {31'h0, s[2]}, 0);
    chk(irq == 1'b0, "R4 idle irq low during gap", {31'h0, irq}, 0);
    repeat (80) @(negedge clk);
    rd(A_STAT, s);
    chk(s[2] == 1'b1, "R6 idle after gap", {31'h0, s[2]}, 1);
    @(negedge clk);
    chk(irq == 1'b1, "R4 idle irq enabled", {31'h0, irq}, 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule